// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block stands between a simple request port and a 16-bit parallel NOR flash device. It carries out two jobs: writing one halfword into erased flash, and erasing one sector. A request gives the job type, a halfword address and, for a write, the data. The block then runs the whole job on the flash bus. That covers the unlock and command write cycles, status polling until the device finishes, the return to array-read mode and, for a write, a read-back check.

When the job ends, the block raises `done` for one cycle with a two-bit result code. While the job runs, `busy` stays high and any new request is ignored. Addresses on the flash port are halfword addresses. A byte-addressed bus would shift them left by one bit.

Top module: `nor_cmd_seq`

## Requirements
- R1: A program job first reads the target. It then issues exactly these writes in order: (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x00A0), (target, data).
- R2: An erase job issues exactly these writes in order: (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x0080), (0x555, 0x00AA), (0x2AA, 0x0055), (sector, 0x0030). No read comes before them.
- R3: If the first read of a program job gives a value v with (v AND data) != data, the job ends with result 3 (not erased). The job makes exactly one read and no write.
- R4: Erase polling reads the sector address. Bit 7 set ends polling with result 0. Otherwise bit 5 set ends polling with result 1 (device error).
- R5: Program polling reads the target and ends with result 0 when read bit 7 equals data bit 7. If bit 7 differs and bit 5 is set, the block reads once more: a bit 7 match then gives result 0, and a mismatch gives result 1.
- R6: If polling has run for at least TIMEOUT_CYC cycles when a poll read returns, the block ends polling with result 2 (timeout).
- R7: Every job that reaches polling ends its bus activity with the write (0x555, 0x00F0). After that write, a program job with result 0 reads the target back, and any difference from the data turns the result into 1.
- R8: After the final write of an erase job, `done` rises exactly SETTLE_CYC+2 cycles after the last cycle with `fl_ce_n` low. The flash bus stays idle in between.
- R9: Each write holds `fl_ce_n` and `fl_we_n` low for exactly WR_PULSE cycles while the data is driven. Each read holds `fl_ce_n` and `fl_oe_n` low for exactly RD_LAT cycles. `fl_we_n` and `fl_oe_n` are never low together.
- R10: After reset, `busy` and `done` are low and all flash strobes are high. A request is taken only while `busy` is low. `busy` then stays high through the one-cycle `done` pulse. Requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a job (taken only while idle) |
| req_erase | input | 1 | 1 = sector erase, 0 = halfword program |
| req_addr | input | AW | Halfword target or sector start address |
| req_data | input | 16 | Data to program |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 ok, 1 device error, 2 timeout, 3 not erased |
| fl_addr | output | AW | Flash halfword address |
| fl_dq_out | output | 16 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 16 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
A write strobe lasts WR_PULSE cycles and a read lasts RD_LAT cycles, each followed by one idle bus cycle. For program jobs, `done` follows one cycle after that idle cycle. For erase jobs, `done` comes SETTLE_CYC+2 cycles after the last cycle with chip enable low. A behavioural flash model samples the strobes at the falling clock edge, half a cycle after each registered change. It logs every write at the rising `fl_we_n` edge, and it measures pulse lengths and the settle gap in whole cycles. Results are compared in the exact cycle where `done` is high, and the cycle after is checked for `busy` low.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_DEVERR  = 2'd1,
        ST_TMO     = 2'd2,
        ST_NERASED = 2'd3
    } nor_status_e;

    typedef enum logic [1:0] {B_IDLE, B_WR, B_RD, B_GAP} bus_st_e;

    typedef enum logic [3:0] {
        P_IDLE, P_PRECHK, P_CMD, P_POLL, P_REREAD,
        P_RESET, P_VERIFY, P_SETTLE, P_DONE
    } seq_ph_e;

    typedef enum logic [1:0] {A_UNLK1, A_UNLK2, A_TGT} asel_e;

    typedef struct packed {
        asel_e       asel;
        logic [15:0] data;
    } cmd_step_t;

    localparam logic [11:0] UNLK1_ADDR = 12'h555;
    localparam logic [11:0] UNLK2_ADDR = 12'h2AA;
    localparam logic [15:0] CMD_RDARR  = 16'h00F0;

    // Command write list for both jobs, indexed by step
    function automatic cmd_step_t seq_step(input logic erase, input logic [2:0] idx,
                                           input logic [15:0] pdata);
        cmd_step_t s;
        s.asel = A_UNLK1;
        s.data = 16'h00AA;
        if (!erase) begin
            case (idx)
                3'd1:    begin s.asel = A_UNLK2; s.data = 16'h0055; end
                3'd2:    begin s.asel = A_UNLK1; s.data = 16'h00A0; end
                3'd3:    begin s.asel = A_TGT;   s.data = pdata;    end
                default: ;
            endcase
        end else begin
            case (idx)
                3'd1, 3'd4: begin s.asel = A_UNLK2; s.data = 16'h0055; end
                3'd2:       begin s.asel = A_UNLK1; s.data = 16'h0080; end
                3'd5:       begin s.asel = A_TGT;   s.data = 16'h0030; end
                default:    ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/nor_cyc_cnt.sv
module nor_cyc_cnt #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)             cnt_d = '0;
        else if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/nor_bus_eng.sv
module nor_bus_eng import nor_seq_pkg::*; #(
    parameter int AW       = 20,
    parameter int WR_PULSE = 4,
    parameter int RD_LAT   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic          ack,
    output logic [15:0]   rdata,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [15:0]   fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int MAXP = (WR_PULSE > RD_LAT) ? WR_PULSE : RD_LAT;
    localparam int CW   = $clog2(MAXP + 1);

    typedef struct packed {
        bus_st_e       st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [15:0]   data;
    } eng_s;

    eng_s q, d;

    always_comb begin
        d = q;
        case (q.st)
            B_IDLE: if (start) begin
                d.st   = wr ? B_WR : B_RD;
                d.cnt  = wr ? CW'(WR_PULSE - 1) : CW'(RD_LAT - 1);
                d.addr = addr;
                d.data = wdata;
            end
            B_WR: if (q.cnt == '0) d.st = B_GAP;
                  else             d.cnt = q.cnt - 1'b1;
            B_RD: if (q.cnt == '0) begin
                      d.st   = B_GAP;
                      d.data = fl_dq_in;
                  end else begin
                      d.cnt = q.cnt - 1'b1;
                  end
            default: d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: B_IDLE, cnt: '0, addr: '0, data: '0};
        else        q <= d;
    end

    assign ack       = (q.st == B_GAP);
    assign rdata     = q.data;
    assign fl_addr   = q.addr;
    assign fl_dq_out = q.data;
    assign fl_dq_oe  = (q.st == B_WR);
    assign fl_ce_n   = !((q.st == B_WR) || (q.st == B_RD));
    assign fl_we_n   = (q.st != B_WR);
    assign fl_oe_n   = (q.st != B_RD);

    // The sequencer must only launch a cycle when the engine is free
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == B_IDLE));

    p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    generate
        if (RD_LAT > 1) begin : g_rd_hold
            p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(fl_oe_n) |=> (!fl_oe_n && $stable(fl_addr)));
        end
    endgenerate

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq import nor_seq_pkg::*; #(
    parameter int AW          = 20,
    parameter int WR_PULSE    = 4,
    parameter int RD_LAT      = 6,
    parameter int TIMEOUT_CYC = 5000000,
    parameter int SETTLE_CYC  = 1000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_erase,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [15:0]   fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int TMAX = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 2);

    typedef struct packed {
        seq_ph_e       ph;
        logic          issued;
        logic [2:0]    step;
        logic          erase;
        logic [AW-1:0] tgt;
        logic [15:0]   data;
        nor_status_e   status;
    } seq_s;

    seq_s q, d;

    logic          eng_start, eng_wr, eng_ack;
    logic [AW-1:0] eng_addr;
    logic [15:0]   eng_wdata, eng_rdata;
    logic          tmr_clr;
    logic [TW-1:0] tmr_cnt;
    cmd_step_t     cur;
    logic          bus_ph, tmo_hit, last_step, bit7_ok;

    always_comb begin
        d         = q;
        cur       = seq_step(q.erase, q.step, q.data);
        eng_wr    = 1'b0;
        eng_addr  = q.tgt;
        eng_wdata = 16'h0000;
        bus_ph    = 1'b0;
        tmo_hit   = (tmr_cnt >= TW'(TIMEOUT_CYC));
        last_step = q.erase ? (q.step == 3'd5) : (q.step == 3'd3);
        bit7_ok   = (eng_rdata[7] == q.data[7]);

        case (q.ph)
            P_PRECHK, P_POLL, P_REREAD, P_VERIFY: bus_ph = 1'b1;
            P_CMD: begin
                bus_ph    = 1'b1;
                eng_wr    = 1'b1;
                eng_wdata = cur.data;
                case (cur.asel)
                    A_UNLK1: eng_addr = AW'(UNLK1_ADDR);
                    A_UNLK2: eng_addr = AW'(UNLK2_ADDR);
                    default: eng_addr = q.tgt;
                endcase
            end
            P_RESET: begin
                bus_ph    = 1'b1;
                eng_wr    = 1'b1;
                eng_addr  = AW'(UNLK1_ADDR);
                eng_wdata = CMD_RDARR;
            end
            default: ;
        endcase

        eng_start = bus_ph && !q.issued;
        if (eng_start) d.issued = 1'b1;

        case (q.ph)
            P_IDLE: if (req_valid) begin
                d.ph     = req_erase ? P_CMD : P_PRECHK;
                d.erase  = req_erase;
                d.tgt    = req_addr;
                d.data   = req_data;
                d.step   = 3'd0;
                d.status = ST_OK;
                d.issued = 1'b0;
            end
            P_SETTLE: if (tmr_cnt >= TW'(SETTLE_CYC - 1)) d.ph = P_DONE;
            P_DONE:   d.ph = P_IDLE;
            default:  ;
        endcase

        if (eng_ack) begin
            d.issued = 1'b0;
            case (q.ph)
                P_PRECHK: if ((eng_rdata & q.data) != q.data) begin
                              d.status = ST_NERASED;
                              d.ph     = P_DONE;
                          end else begin
                              d.ph = P_CMD;
                          end
                P_CMD: if (last_step) d.ph = P_POLL;
                       else           d.step = q.step + 3'd1;
                P_POLL: begin
                    if (tmo_hit) begin
                        d.status = ST_TMO;
                        d.ph     = P_RESET;
                    end else if (q.erase) begin
                        if (eng_rdata[7])      d.ph = P_RESET;
                        else if (eng_rdata[5]) begin
                            d.status = ST_DEVERR;
                            d.ph     = P_RESET;
                        end
                    end else begin
                        if (bit7_ok)           d.ph = P_RESET;
                        else if (eng_rdata[5]) d.ph = P_REREAD;
                    end
                end
                P_REREAD: begin
                    if (!bit7_ok) d.status = ST_DEVERR;
                    d.ph = P_RESET;
                end
                P_RESET: begin
                    if (q.erase)                d.ph = P_SETTLE;
                    else if (q.status == ST_OK) d.ph = P_VERIFY;
                    else                        d.ph = P_DONE;
                end
                P_VERIFY: begin
                    if (eng_rdata != q.data) d.status = ST_DEVERR;
                    d.ph = P_DONE;
                end
                default: ;
            endcase
        end

        tmr_clr = !((q.ph == P_POLL) || (q.ph == P_REREAD) || (q.ph == P_SETTLE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: P_IDLE, issued: 1'b0, step: 3'd0, erase: 1'b0,
                           tgt: '0, data: '0, status: ST_OK};
        else        q <= d;
    end

    nor_bus_eng #(.AW(AW), .WR_PULSE(WR_PULSE), .RD_LAT(RD_LAT)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .wr(eng_wr),
        .addr(eng_addr), .wdata(eng_wdata), .ack(eng_ack), .rdata(eng_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    nor_cyc_cnt #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr_cnt)
    );

    assign busy   = (q.ph != P_IDLE);
    assign done   = (q.ph == P_DONE);
    assign status = q.status;

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> fl_ce_n);
    p_poll_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == P_POLL) |-> fl_we_n);
    p_settle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == P_SETTLE) |-> fl_ce_n);

endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int AW  = 20;
    localparam int WRP = 2;
    localparam int RDL = 3;
    localparam int TMO = 200;
    localparam int STL = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0, req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          busy, done;
    logic [1:0]    status;
    logic [AW-1:0] fl_addr;
    logic [15:0]   fl_dq_out;
    logic          fl_dq_oe;
    logic [15:0]   fl_dq_in = 16'h0000;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    nor_cmd_seq #(.AW(AW), .WR_PULSE(WRP), .RD_LAT(RDL), .TIMEOUT_CYC(TMO),
                  .SETTLE_CYC(STL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .status(status), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int nchk = 0, nbad = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural flash model
    logic [15:0] mem [int];
    int   k_left = 0;
    bit   k_err = 0, k_errdone = 0, k_corrupt = 0, k_hang = 0;
    int   fm_mode = 0, fm_addr = 0, fm_cnt = 0;
    logic [15:0] fm_data = '0;
    bit   arm_p = 0, arm_e = 0;
    logic [35:0] wlog [$];
    logic [35:0] expw [$];
    int   rd_cnt = 0, cyc = 0, last_ce = 0, wlen = 0, rlen = 0;
    logic pwe = 1'b1, poe = 1'b1;

    function automatic logic [15:0] rdval(input int a);
        if (fm_mode == 1 && a == fm_addr) return {8'h00, ~fm_data[7], 1'b0, k_err, 5'h00};
        if (fm_mode == 2) return {8'h00, 1'b0, 1'b0, k_err, 5'h00};
        return mem.exists(a) ? mem[a] : 16'hFFFF;
    endfunction

    task automatic fm_finish();
        logic [15:0] old;
        old = mem.exists(fm_addr) ? mem[fm_addr] : 16'hFFFF;
        if (fm_mode == 1) mem[fm_addr] = (old & fm_data) ^ (k_corrupt ? 16'h0100 : 16'h0000);
        else              mem[fm_addr] = 16'hFFFF;
        fm_mode = 0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            int a;
            logic [15:0] dv;
            a  = int'(fl_addr);
            dv = fl_dq_out;
            if (!fl_ce_n) last_ce = cyc;
            if (!fl_we_n && !fl_oe_n) chk(0, "R9", "we and oe both low", 1, 0);
            if (!fl_we_n && (fl_ce_n || !fl_dq_oe)) chk(0, "R9", "write without ce or drive", 0, 1);
            if (!fl_oe_n && fl_ce_n) chk(0, "R9", "read without ce", 1, 0);
            if (!fl_we_n) wlen++;
            if (!fl_oe_n) rlen++;
            if (fl_we_n && !pwe) begin
                chk(wlen == WRP, "R9", "write pulse length", wlen, WRP);
                wlen = 0;
                wlog.push_back({fl_addr, dv});
                if (dv == 16'h00F0) begin fm_mode = 0; arm_p = 0; arm_e = 0; end
                else if (arm_p) begin
                    arm_p = 0; fm_mode = 1; fm_addr = a; fm_data = dv; fm_cnt = k_left;
                end
                else if (dv == 16'h00A0 && a == 'h555) arm_p = 1;
                else if (dv == 16'h0080) arm_e = 1;
                else if (dv == 16'h0030 && arm_e) begin
                    arm_e = 0; fm_mode = 2; fm_addr = a; fm_cnt = k_left;
                end
            end
            if (fl_oe_n && !poe) begin
                chk(rlen == RDL, "R9", "read length", rlen, RDL);
                rlen = 0;
                rd_cnt++;
                if (fm_mode != 0 && !k_hang) begin
                    if (k_err) begin
                        if (k_errdone) fm_finish();
                    end else if (fm_cnt == 0) fm_finish();
                    else fm_cnt--;
                end
            end
            pwe = fl_we_n;
            poe = fl_oe_n;
            fl_dq_in = fl_oe_n ? 16'h0000 : rdval(a);
        end
    end

    function automatic logic [35:0] wr_ent(input int a, input int dv);
        return {20'(a), 16'(dv)};
    endfunction

    task automatic exp_prog(input int a, input int dv);
        expw.push_back(wr_ent('h555, 'hAA)); expw.push_back(wr_ent('h2AA, 'h55));
        expw.push_back(wr_ent('h555, 'hA0)); expw.push_back(wr_ent(a, dv));
    endtask

    task automatic exp_erase(input int a);
        expw.push_back(wr_ent('h555, 'hAA)); expw.push_back(wr_ent('h2AA, 'h55));
        expw.push_back(wr_ent('h555, 'h80)); expw.push_back(wr_ent('h555, 'hAA));
        expw.push_back(wr_ent('h2AA, 'h55)); expw.push_back(wr_ent(a, 'h30));
    endtask

    int dcyc = 0, dce = 0;

    task automatic run_op(input bit er, input int a, input logic [15:0] dv,
                          input int exp_st, input int inj, input string tag);
        int n;
        wlog.delete();
        rd_cnt = 0;
        chk(!busy, "R10", {tag, " idle before request"}, busy, 0);
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_addr = AW'(a); req_data = dv;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        forever begin
            chk(busy, "R10", {tag, " busy during job"}, busy, 1);
            if (done) break;
            if (inj > 0 && n == inj) begin
                req_valid = 1'b1; req_erase = 1'b1; req_addr = AW'('h3000); req_data = '0;
            end
            if (inj > 0 && n == inj + 1) req_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        dcyc = cyc;
        dce  = last_ce;
        chk(status == 2'(exp_st), tag, "result code", status, exp_st);
        chk(wlog.size() == expw.size(), tag, "write count", wlog.size(), expw.size());
        foreach (expw[i])
            if (i < wlog.size()) chk(wlog[i] == expw[i], tag, "write cycle", wlog[i], expw[i]);
        expw.delete();
        @(negedge clk);
        chk(!busy && !done, "R10", {tag, " idle after done"}, {busy, done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R10", "reset outputs", {busy, done}, 0);
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R10", "reset strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R5 R7: clean program
        k_left = 2;
        exp_prog('h100, 'h1234); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h100, 16'h1234, 0, 0, "R1");

        // R3: not erased, no writes, one read
        run_op(0, 'h100, 16'h0001, 3, 0, "R3");
        chk(rd_cnt == 1, "R3", "read count", rd_cnt, 1);

        // R3 boundary: subset of current bits is accepted
        k_left = 0;
        exp_prog('h100, 'h1230); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h100, 16'h1230, 0, 0, "R3");

        // R5: error flag, then done on the extra read
        k_err = 1; k_errdone = 1;
        exp_prog('h200, 'h0011); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h200, 16'h0011, 0, 0, "R5");

        // R5: error flag persists
        k_errdone = 0;
        exp_prog('h201, 'h00A5); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h201, 16'h00A5, 1, 0, "R5");
        k_err = 0;

        // R7: read-back mismatch
        k_corrupt = 1; k_left = 1;
        exp_prog('h202, 'h00FF); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h202, 16'h00FF, 1, 0, "R7");
        k_corrupt = 0;

        // R6: program never finishes
        k_hang = 1;
        exp_prog('h203, 'h0F0F); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h203, 16'h0F0F, 2, 0, "R6");

        // R6 R8: erase never finishes
        exp_erase('h9000); expw.push_back(wr_ent('h555, 'hF0));
        run_op(1, 'h9000, 16'h0000, 2, 0, "R6");
        chk(dcyc - dce == STL + 2, "R8", "settle after timeout", dcyc - dce, STL + 2);
        k_hang = 0;

        // R2 R4 R8: clean erase
        k_left = 3;
        exp_erase('h8000); expw.push_back(wr_ent('h555, 'hF0));
        run_op(1, 'h8000, 16'h0000, 0, 0, "R2");
        chk(dcyc - dce == STL + 2, "R8", "settle gap", dcyc - dce, STL + 2);

        // R4: erase error flag
        k_err = 1; k_errdone = 0;
        exp_erase('hA000); expw.push_back(wr_ent('h555, 'hF0));
        run_op(1, 'hA000, 16'h0000, 1, 0, "R4");
        chk(dcyc - dce == STL + 2, "R8", "settle after error", dcyc - dce, STL + 2);
        k_err = 0;

        // R10: request while busy is ignored
        k_left = 1;
        exp_prog('h300, 'h5A5A); expw.push_back(wr_ent('h555, 'hF0));
        run_op(0, 'h300, 16'h5A5A, 0, 5, "R10");
        wlog.delete();
        repeat (20) @(negedge clk);
        chk(!busy && wlog.size() == 0, "R10", "no job from ignored request", wlog.size(), 0);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule